// File: doc/BRIEF.md
# Write-Once-Window System Configuration Register

This block holds an 8-bit system configuration word whose bits feed clock, interrupt and supervision logic elsewhere on the chip. Three of the bits may be changed by software at any time. The other five are guarded. In normal operation, software gets a single chance to set them, and that chance exists only during a short window that opens when reset is released. After the first write in that window, or once the window has expired, the guarded bits ignore further writes until the next reset.

A special-mode input lifts the guard. While it is high, every bit is writable on every write, any number of times, and such writes do not use up the single normal-mode chance. Reads always return the full word. Each bit is also driven on its own output so that consumers can use it directly.

Top module: `syscfg_lock_reg`

## Requirements
- R1: While `rst` is high, the register is loaded with 0x10, meaning only bit 4 (oscillator start-up delay) is set. The post-reset window counter also restarts from zero.
- R2: Bits 7 (ADC power-up), 6 (clock select) and 3 (clock-monitor enable) are unguarded. Every write loads them from `wr_data`, in any mode and at any time.
- R3: The guarded bits are 5 (IRQ edge select), 4 (start-up delay), 2 (force clock-monitor), 1 and 0 (rate select). In normal mode, the first write inside the window loads them from `wr_data`.
- R4: After that first normal-mode write, the guarded bits are locked until reset. Later normal-mode writes, even inside the window, change only the unguarded bits.
- R5: The window covers the first 64 rising clock edges after `rst` falls. A normal-mode write on the 65th edge or later leaves the guarded bits unchanged, even if no write happened earlier. The counter saturates at 64 and does not wrap.
- R6: While `special_mode` is high, each write loads all eight bits, at any time and any number of times. A special-mode write does not consume the normal-mode one-shot.
- R7: `rd_data` always returns all eight bits. Each dedicated output equals its bit of `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| special_mode | input | 1 | High: guarded bits writable without restriction |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Current register contents |
| cfg_adc_pwr | output | 1 | Bit 7, ADC power-up |
| cfg_clk_sel | output | 1 | Bit 6, clock select |
| cfg_irq_edge | output | 1 | Bit 5, IRQ edge select |
| cfg_osc_delay | output | 1 | Bit 4, oscillator start-up delay |
| cfg_cmon_en | output | 1 | Bit 3, clock-monitor enable |
| cfg_cmon_force | output | 1 | Bit 2, force clock-monitor |
| cfg_rate | output | 2 | Bits 1:0, rate select |

## Verification
Two events can fall on the same clock edge: the window closing and a write arriving. A write on the 64th edge after reset must still be accepted, and one on the 65th must be refused. The bench places single writes exactly on those two edges after fresh resets and compares the guarded bits with the written and reset values. A second pairing is a special-mode write arriving after the lock has been taken, together with a normal-mode write arriving inside the window just after a special-mode write. The bench judges both by reading back the word after each write.

// File: rtl/syscfg_pkg.sv
package syscfg_pkg;
  localparam int CFG_W = 8;
  localparam logic [CFG_W-1:0] CFG_RESET     = 8'h10;
  localparam logic [CFG_W-1:0] CFG_PROT_MASK = 8'h37;
  localparam int B_ADC_PWR    = 7;
  localparam int B_CLK_SEL    = 6;
  localparam int B_IRQ_EDGE   = 5;
  localparam int B_OSC_DELAY  = 4;
  localparam int B_CMON_EN    = 3;
  localparam int B_CMON_FORCE = 2;
  localparam int B_RATE_HI    = 1;
  localparam int B_RATE_LO    = 0;
endpackage

// File: rtl/boot_window_timer.sv
module boot_window_timer #(
  parameter int WINDOW_CYCLES = 64,
  localparam int CNT_W = $clog2(WINDOW_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  output logic win_open
);
  localparam logic [CNT_W-1:0] WIN_END = CNT_W'(WINDOW_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                 cnt_q <= '0;
    else if (cnt_q != WIN_END) cnt_q <= cnt_q + 1'b1;
  end

  assign win_open = (cnt_q != WIN_END);

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= WIN_END);
  p_cnt_sat_r5: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == WIN_END) |=> (cnt_q == WIN_END));
endmodule

// File: rtl/prot_lock.sv
module prot_lock (
  input  logic clk,
  input  logic rst,
  input  logic special_mode,
  input  logic wr_en,
  input  logic win_open,
  output logic prot_wr_ok
);
  logic lock_q;

  always_ff @(posedge clk) begin
    if (rst)                                     lock_q <= 1'b0;
    else if (wr_en && !special_mode && win_open) lock_q <= 1'b1;
  end

  assign prot_wr_ok = special_mode || (win_open && !lock_q);

  p_lock_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> lock_q);
  p_lock_take_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !special_mode && win_open) |=> lock_q);
endmodule

// File: rtl/cfg_bits.sv
module cfg_bits
  import syscfg_pkg::*;
#(
  parameter int W = CFG_W,
  parameter logic [W-1:0] RESET_VAL = CFG_RESET,
  parameter logic [W-1:0] PROT_MASK = CFG_PROT_MASK
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic         prot_wr_ok,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic ld;
    if (PROT_MASK[i]) begin : g_prot
      assign ld = wr_en && prot_wr_ok;
    end else begin : g_free
      assign ld = wr_en;
    end
    always_ff @(posedge clk) begin
      if (rst)     q[i] <= RESET_VAL[i];
      else if (ld) q[i] <= wr_data[i];
    end
  end

  p_reset_val_r1: assert property (@(posedge clk)
    rst |=> (q == RESET_VAL));
  p_unprot_follow_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((q & ~PROT_MASK) == ($past(wr_data) & ~PROT_MASK)));
  p_prot_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && prot_wr_ok) |=> ((q & PROT_MASK) == ($past(q) & PROT_MASK)));
endmodule

// File: rtl/syscfg_lock_reg.sv
module syscfg_lock_reg
  import syscfg_pkg::*;
#(
  parameter int WINDOW_CYCLES = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             special_mode,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output logic [CFG_W-1:0] rd_data,
  output logic             cfg_adc_pwr,
  output logic             cfg_clk_sel,
  output logic             cfg_irq_edge,
  output logic             cfg_osc_delay,
  output logic             cfg_cmon_en,
  output logic             cfg_cmon_force,
  output logic [1:0]       cfg_rate
);
  logic win_open;
  logic prot_wr_ok;
  logic [CFG_W-1:0] cfg_q;

  boot_window_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .win_open(win_open)
  );

  prot_lock u_lock (
    .clk(clk), .rst(rst), .special_mode(special_mode), .wr_en(wr_en),
    .win_open(win_open), .prot_wr_ok(prot_wr_ok)
  );

  cfg_bits #(.W(CFG_W), .RESET_VAL(CFG_RESET), .PROT_MASK(CFG_PROT_MASK)) u_bits (
    .clk(clk), .rst(rst), .wr_en(wr_en), .prot_wr_ok(prot_wr_ok),
    .wr_data(wr_data), .q(cfg_q)
  );

  assign rd_data        = cfg_q;
  assign cfg_adc_pwr    = cfg_q[B_ADC_PWR];
  assign cfg_clk_sel    = cfg_q[B_CLK_SEL];
  assign cfg_irq_edge   = cfg_q[B_IRQ_EDGE];
  assign cfg_osc_delay  = cfg_q[B_OSC_DELAY];
  assign cfg_cmon_en    = cfg_q[B_CMON_EN];
  assign cfg_cmon_force = cfg_q[B_CMON_FORCE];
  assign cfg_rate       = cfg_q[B_RATE_HI:B_RATE_LO];

  p_special_load_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && special_mode) |=> (rd_data == $past(wr_data)));
endmodule

// File: tb/tb_syscfg_lock_reg.sv
module tb_syscfg_lock_reg;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic special_mode = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic adc, csel, irq, dly, cmen, cmf;
  logic [1:0] rate;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  syscfg_lock_reg dut (
    .clk(clk), .rst(rst), .special_mode(special_mode), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .cfg_adc_pwr(adc),
    .cfg_clk_sel(csel), .cfg_irq_edge(irq), .cfg_osc_delay(dly),
    .cfg_cmon_en(cmen), .cfg_cmon_force(cmf), .cfg_rate(rate)
  );

  // {special, write data, expected word}
  localparam logic [16:0] VEC [6] = '{
    {1'b0, 8'hA5, 8'hA5},
    {1'b0, 8'h5A, 8'h6D},
    {1'b1, 8'h12, 8'h12},
    {1'b1, 8'hF3, 8'hF3},
    {1'b0, 8'h00, 8'h33},
    {1'b0, 8'h08, 8'h3B}
  };

  task automatic check(input string req, input logic [7:0] exp);
    logic [7:0] outs;
    outs = {adc, csel, irq, dly, cmen, cmf, rate};
    total++;
    if (rd_data !== exp || outs !== exp) begin
      bad++;
      $display("FAIL %s: rd=%h outs=%h expected=%h", req, rd_data, outs, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; wr_en = 1'b0; special_mode = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input logic sp, input logic [7:0] d);
    special_mode = sp; wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; special_mode = 1'b0;
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: rd=%h expected=finish", rd_data);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 reset value", 8'h10);
    rst = 1'b0;

    // table walk from count 0: R3 first write, R4 lock, R2 free bits, R6 special
    for (int i = 0; i < 6; i++) begin
      do_write(VEC[i][16], VEC[i][15:8]);
      check("R2/R3/R4/R6 table", VEC[i][7:0]);
    end

    // R2: free bits after window close, guarded kept
    idle(100);
    do_write(1'b0, 8'hC0);
    check("R2 free bits late", 8'hF3);
    do_write(1'b0, 8'h00);
    check("R2 cmon clear late", 8'h33);

    // R1: reset restores value
    do_reset();
    check("R1 reset after use", 8'h10);

    // R5: no write in window, late write refused for guarded bits
    idle(80);
    do_write(1'b0, 8'hFF);
    check("R5 late write no lock", 8'hD8);

    // R5: last edge inside window accepted
    do_reset();
    idle(63);
    do_write(1'b0, 8'h07);
    check("R5 write on 64th edge", 8'h07);

    // R5: first edge after window refused
    do_reset();
    idle(64);
    do_write(1'b0, 8'h07);
    check("R5 write on 65th edge", 8'h10);

    // R6: special-mode write does not consume one-shot
    do_reset();
    do_write(1'b1, 8'h01);
    check("R6 special in window", 8'h01);
    do_write(1'b0, 8'h02);
    check("R6 one-shot still free", 8'h02);
    do_write(1'b0, 8'h00);
    check("R4 locked after normal write", 8'h02);

    // R7: reads unaffected by idle time / lock
    idle(5);
    check("R7 readback", 8'h02);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule